// File: doc/BRIEF.md
# Two-phase store buffer

This block holds stores between issue and memory in an out-of-order back end that renames registers by tag. At issue a store brings its base register and its data. Each of them is either a value or the tag of the unit that will produce it. The store also brings a signed offset. The store takes a free slot. While a slot waits, it watches the result broadcast bus and takes any missing base or data value whose tag matches.

A store runs in two steps. In the first, once the base value is present, one shared adder forms the effective address, base plus the sign-extended offset, and writes it back into the slot. In the second, the oldest store leaves for the memory port over a valid/ready handshake, but only when its address and its data are both present. The slot is released in the cycle the port accepts the write. When every slot is taken, the block raises a full flag and discards any store offered at issue.

Top module: `store_buf`

## Requirements
- R1: After reset the buffer is empty: `full_o` is 0 and `mem_wr_valid_o` is 0.
- R2: A store is taken when `issue_valid_i` is 1 and `full_o` is 0. `full_o` is 1 exactly when all `N_ENT` slots are occupied. A store offered while `full_o` is 1 is discarded and never reaches memory.
- R3: The write address is the base value plus `issue_off_i` sign-extended from `OW` bits to `DW` bits, modulo 2^DW.
- R4: An address is formed only once the slot holds its base value, in the first clock edge after that value arrives. When several slots are eligible, the oldest goes first, and at most one slot gains an address per cycle.
- R5: A slot that waits on an operand takes `cdb_value_i` when `cdb_valid_i` is 1 and `cdb_tag_i` equals that operand's tag. A broadcast with any other tag is ignored. An operand issued as a value (ready flag 1) ignores every broadcast, even one carrying its tag field.
- R6: A broadcast in the same cycle as the issue of a store satisfies a not-ready base or data operand of that store whose tag matches.
- R7: Stores reach the memory port in issue order. A younger store that is ready never goes before an older store that is still waiting.
- R8: `mem_wr_valid_o` is 1 only when the oldest store has both its address and its data. While `mem_wr_ready_i` is 0, the address and data hold steady. The slot is freed in the cycle of acceptance and can be used again.
- R9: The data written is the data value given at issue, or the broadcast value taken for the data tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | A store is offered at issue |
| issue_base_rdy_i | input | 1 | The base is a value (1) or a tag (0) |
| issue_base_i | input | DW | Base register value |
| issue_base_tag_i | input | TW | Producer tag of the base |
| issue_off_i | input | OW | Signed address offset |
| issue_data_rdy_i | input | 1 | The data is a value (1) or a tag (0) |
| issue_data_i | input | DW | Store data value |
| issue_data_tag_i | input | TW | Producer tag of the data |
| full_o | output | 1 | Every slot is occupied; issue is refused |
| cdb_valid_i | input | 1 | A result is broadcast this cycle |
| cdb_tag_i | input | TW | Tag of the broadcast result |
| cdb_value_i | input | DW | Broadcast result value |
| mem_wr_valid_o | output | 1 | A store write is offered to memory |
| mem_wr_addr_o | output | DW | Effective address of the offered write |
| mem_wr_data_o | output | DW | Data of the offered write |
| mem_wr_ready_i | input | 1 | The memory port accepts the write |

## Verification
The cases that are hard to reach from the ports are a broadcast landing in the very cycle its consumer is issued, and an old store still waiting on data while a younger store behind it is already complete. Directed sequences set up both of these with known tags and values. Random traffic then keeps a table of outstanding tags with fixed values, reuses those tags across several waiting stores, and stalls the memory port at random. A bench model in issue order predicts every address and data pair.

// File: rtl/store_buf_pkg.sv
package store_buf_pkg;
  localparam int unsigned SB_N_ENT = 4;
  localparam int unsigned SB_DW    = 32;
  localparam int unsigned SB_TW    = 4;
  localparam int unsigned SB_OW    = 12;

  typedef enum logic [1:0] {
    PH_EMPTY     = 2'd0,
    PH_BASE_WAIT = 2'd1,
    PH_BASE_RDY  = 2'd2,
    PH_ADDR_RDY  = 2'd3
  } sb_phase_e;

  function automatic int unsigned sb_wrap_inc(int unsigned i, int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction
endpackage

// File: rtl/store_buf_slot.sv
module store_buf_slot
  import store_buf_pkg::*;
#(
  parameter int unsigned DW = SB_DW,
  parameter int unsigned TW = SB_TW,
  parameter int unsigned OW = SB_OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          a_base_rdy_i,
  input  logic [DW-1:0] a_base_i,
  input  logic [TW-1:0] a_base_tag_i,
  input  logic [OW-1:0] a_off_i,
  input  logic          a_data_rdy_i,
  input  logic [DW-1:0] a_data_i,
  input  logic [TW-1:0] a_data_tag_i,
  input  logic          cdb_valid_i,
  input  logic [TW-1:0] cdb_tag_i,
  input  logic [DW-1:0] cdb_value_i,
  input  logic          ea_we_i,
  input  logic [DW-1:0] ea_i,
  input  logic          free_i,
  output sb_phase_e     phase_o,
  output logic [DW-1:0] fld_o,
  output logic [OW-1:0] off_o,
  output logic          data_rdy_o,
  output logic [DW-1:0] data_o
);
  sb_phase_e     phase_q;
  logic [DW-1:0] fld_q;    // base value, then effective address
  logic [TW-1:0] btag_q;
  logic [OW-1:0] off_q;
  logic          drdy_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] dtag_q;

  logic new_bhit, new_dhit, bhit, dhit;
  assign new_bhit = cdb_valid_i && (cdb_tag_i == a_base_tag_i);
  assign new_dhit = cdb_valid_i && (cdb_tag_i == a_data_tag_i);
  assign bhit     = cdb_valid_i && (cdb_tag_i == btag_q) && (phase_q == PH_BASE_WAIT);
  assign dhit     = cdb_valid_i && (cdb_tag_i == dtag_q) && (phase_q != PH_EMPTY) && !drdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_EMPTY;
      fld_q   <= '0;
      btag_q  <= '0;
      off_q   <= '0;
      drdy_q  <= 1'b0;
      data_q  <= '0;
      dtag_q  <= '0;
    end else if (alloc_i) begin
      btag_q <= a_base_tag_i;
      off_q  <= a_off_i;
      dtag_q <= a_data_tag_i;
      if (a_base_rdy_i) begin
        phase_q <= PH_BASE_RDY;
        fld_q   <= a_base_i;
      end else if (new_bhit) begin
        phase_q <= PH_BASE_RDY;
        fld_q   <= cdb_value_i;
      end else begin
        phase_q <= PH_BASE_WAIT;
        fld_q   <= '0;
      end
      if (a_data_rdy_i) begin
        drdy_q <= 1'b1;
        data_q <= a_data_i;
      end else if (new_dhit) begin
        drdy_q <= 1'b1;
        data_q <= cdb_value_i;
      end else begin
        drdy_q <= 1'b0;
        data_q <= '0;
      end
    end else if (free_i) begin
      phase_q <= PH_EMPTY;
      drdy_q  <= 1'b0;
    end else begin
      if (bhit) begin
        phase_q <= PH_BASE_RDY;
        fld_q   <= cdb_value_i;
      end
      if (ea_we_i) begin
        phase_q <= PH_ADDR_RDY;
        fld_q   <= ea_i;
      end
      if (dhit) begin
        drdy_q <= 1'b1;
        data_q <= cdb_value_i;
      end
    end
  end

  assign phase_o    = phase_q;
  assign fld_o      = fld_q;
  assign off_o      = off_q;
  assign data_rdy_o = drdy_q;
  assign data_o     = data_q;
endmodule

// File: rtl/store_buf_pick.sv
module store_buf_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] head_i,
  output logic [N-1:0]  gnt_o
);
  // first requester at or after head, in circular order
  always_comb begin
    logic          found;
    int unsigned   s;
    logic [IW-1:0] idx;
    gnt_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      s = 32'(head_i) + 32'(k);
      if (s >= N) s = s - N;
      idx = IW'(s);
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/store_buf.sv
module store_buf
  import store_buf_pkg::*;
#(
  parameter int unsigned N_ENT = SB_N_ENT,
  parameter int unsigned DW    = SB_DW,
  parameter int unsigned TW    = SB_TW,
  parameter int unsigned OW    = SB_OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_valid_i,
  input  logic          issue_base_rdy_i,
  input  logic [DW-1:0] issue_base_i,
  input  logic [TW-1:0] issue_base_tag_i,
  input  logic [OW-1:0] issue_off_i,
  input  logic          issue_data_rdy_i,
  input  logic [DW-1:0] issue_data_i,
  input  logic [TW-1:0] issue_data_tag_i,
  output logic          full_o,
  input  logic          cdb_valid_i,
  input  logic [TW-1:0] cdb_tag_i,
  input  logic [DW-1:0] cdb_value_i,
  output logic          mem_wr_valid_o,
  output logic [DW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  input  logic          mem_wr_ready_i
);
  localparam int unsigned IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int unsigned CW = $clog2(N_ENT + 1);

  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  sb_phase_e     phase [N_ENT];
  logic [DW-1:0] fld   [N_ENT];
  logic [OW-1:0] off   [N_ENT];
  logic [DW-1:0] data  [N_ENT];
  logic [N_ENT-1:0] drdy, base_rdy_w, addr_rdy_w, gnt, alloc, free;

  logic issue_go, mem_go;
  logic [DW-1:0] sel_fld, ea;
  logic [OW-1:0] sel_off;

  assign full_o   = (cnt_q == CW'(N_ENT));
  assign issue_go = issue_valid_i && !full_o;
  assign mem_go   = mem_wr_valid_o && mem_wr_ready_i;

  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
      assign alloc[g]      = issue_go && (tail_q == IW'(g));
      assign free[g]       = mem_go && (head_q == IW'(g));
      assign base_rdy_w[g] = (phase[g] == PH_BASE_RDY);
      assign addr_rdy_w[g] = (phase[g] == PH_ADDR_RDY);

      store_buf_slot #(.DW(DW), .TW(TW), .OW(OW)) u_slot (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .alloc_i     (alloc[g]),
        .a_base_rdy_i(issue_base_rdy_i),
        .a_base_i    (issue_base_i),
        .a_base_tag_i(issue_base_tag_i),
        .a_off_i     (issue_off_i),
        .a_data_rdy_i(issue_data_rdy_i),
        .a_data_i    (issue_data_i),
        .a_data_tag_i(issue_data_tag_i),
        .cdb_valid_i (cdb_valid_i),
        .cdb_tag_i   (cdb_tag_i),
        .cdb_value_i (cdb_value_i),
        .ea_we_i     (gnt[g]),
        .ea_i        (ea),
        .free_i      (free[g]),
        .phase_o     (phase[g]),
        .fld_o       (fld[g]),
        .off_o       (off[g]),
        .data_rdy_o  (drdy[g]),
        .data_o      (data[g])
      );
    end
  endgenerate

  // single shared address adder, oldest eligible slot wins
  store_buf_pick #(.N(N_ENT)) u_pick (
    .req_i (base_rdy_w),
    .head_i(head_q),
    .gnt_o (gnt)
  );

  always_comb begin
    sel_fld = '0;
    sel_off = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (gnt[i]) begin
        sel_fld = sel_fld | fld[i];
        sel_off = sel_off | off[i];
      end
    end
  end

  assign ea = sel_fld + {{(DW-OW){sel_off[OW-1]}}, sel_off};

  assign mem_wr_valid_o = addr_rdy_w[head_q] && drdy[head_q];
  assign mem_wr_addr_o  = fld[head_q];
  assign mem_wr_data_o  = data[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (issue_go) tail_q <= IW'(sb_wrap_inc(32'(tail_q), N_ENT));
      if (mem_go)   head_q <= IW'(sb_wrap_inc(32'(head_q), N_ENT));
      if (issue_go && !mem_go)      cnt_q <= cnt_q + 1'b1;
      else if (!issue_go && mem_go) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/store_buf_chk.sv
module store_buf_chk #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = $clog2(N_ENT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             full_o,
  input logic             mem_wr_valid_o,
  input logic             mem_wr_ready_i,
  input logic [DW-1:0]    mem_wr_addr_o,
  input logic [DW-1:0]    mem_wr_data_o,
  input logic [CW-1:0]    cnt_q,
  input logic [N_ENT-1:0] addr_rdy_w
);
  assert_empty_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> (!mem_wr_valid_o && !full_o));

  assert_full_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !(mem_wr_valid_o && mem_wr_ready_i)) |=> full_o);

  assert_one_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(addr_rdy_w) <= $countones($past(addr_rdy_w)) + 1);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && mem_wr_ready_i) |=>
      (int'(cnt_q) == int'($past(cnt_q)) + int'($past(issue_valid_i && !full_o)) - 1));
endmodule

bind store_buf store_buf_chk #(.N_ENT(N_ENT), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .full_o        (full_o),
  .mem_wr_valid_o(mem_wr_valid_o),
  .mem_wr_ready_i(mem_wr_ready_i),
  .mem_wr_addr_o (mem_wr_addr_o),
  .mem_wr_data_o (mem_wr_data_o),
  .cnt_q         (cnt_q),
  .addr_rdy_w    (addr_rdy_w)
);

// File: tb/tb_store_buf.sv
`timescale 1ns/1ps
module tb_store_buf;
  localparam int N = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 0, issue_base_rdy_i = 0, issue_data_rdy_i = 0;
  logic [31:0] issue_base_i = 0, issue_data_i = 0;
  logic [3:0]  issue_base_tag_i = 0, issue_data_tag_i = 0;
  logic [11:0] issue_off_i = 0;
  logic        full_o;
  logic        cdb_valid_i = 0;
  logic [3:0]  cdb_tag_i = 0;
  logic [31:0] cdb_value_i = 0;
  logic        mem_wr_valid_o;
  logic [31:0] mem_wr_addr_o, mem_wr_data_o;
  logic        mem_wr_ready_i = 0;

  always #2 clk_i = ~clk_i;

  store_buf #(.N_ENT(N), .DW(32), .TW(4), .OW(12)) dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] exp_a[$], exp_d[$];
  logic [31:0] tag_val [16];
  bit          pend    [16];

  function automatic logic [31:0] ea_of(logic [31:0] b, logic [11:0] o);
    return b + {{20{o[11]}}, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: model bookkeeping, then the edge; inputs held until after it
  task automatic cyc();
    if (issue_valid_i && !full_o) begin
      exp_a.push_back(ea_of(issue_base_rdy_i ? issue_base_i : tag_val[issue_base_tag_i], issue_off_i));
      exp_d.push_back(issue_data_rdy_i ? issue_data_i : tag_val[issue_data_tag_i]);
    end
    if (mem_wr_valid_o && mem_wr_ready_i) begin
      if (exp_a.size() == 0) begin
        chk(0, "R2/R7 write with no store pending", mem_wr_addr_o, 32'hx);
      end else begin
        chk(mem_wr_addr_o == exp_a[0], "R3/R7 address", mem_wr_addr_o, exp_a[0]);
        chk(mem_wr_data_o == exp_d[0], "R9/R7 data", mem_wr_data_o, exp_d[0]);
        void'(exp_a.pop_front());
        void'(exp_d.pop_front());
      end
    end
    @(posedge clk_i);
    #1;
    issue_valid_i = 0;
    cdb_valid_i   = 0;
  endtask

  task automatic issue_st(input bit br, input logic [31:0] b, input logic [3:0] bt, input logic [11:0] o,
                          input bit dr, input logic [31:0] d, input logic [3:0] dt);
    issue_valid_i = 1; issue_base_rdy_i = br; issue_base_i = b; issue_base_tag_i = bt;
    issue_off_i = o; issue_data_rdy_i = dr; issue_data_i = d; issue_data_tag_i = dt;
    cyc();
  endtask

  task automatic set_cdb(input logic [3:0] t);
    cdb_valid_i = 1; cdb_tag_i = t; cdb_value_i = tag_val[t];
  endtask

  task automatic bcast(input logic [3:0] t);
    set_cdb(t);
    cyc();
  endtask

  task automatic claim(input logic [3:0] t);
    if (!pend[t]) begin
      pend[t] = 1;
      tag_val[t] = $urandom;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL R8 watchdog: actual hung expected drained");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) begin tag_val[i] = 0; pend[i] = 0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    #1;
    chk(full_o == 0, "R1 full after reset", full_o, 0);
    chk(mem_wr_valid_o == 0, "R1 valid after reset", mem_wr_valid_o, 0);

    // R3/R4: ready store, negative offset, address one edge after entry
    mem_wr_ready_i = 0;
    issue_st(1, 32'h100, 0, 12'hFFC, 1, 32'hAB, 0);
    chk(mem_wr_valid_o == 0, "R4 address takes one edge", mem_wr_valid_o, 0);
    cyc();
    chk(mem_wr_valid_o == 1, "R8 valid with addr+data", mem_wr_valid_o, 1);
    chk(mem_wr_addr_o == 32'hFC, "R3 sign-extended offset", mem_wr_addr_o, 32'hFC);
    cyc();
    chk(mem_wr_addr_o == 32'hFC, "R8 held while stalled", mem_wr_addr_o, 32'hFC);
    mem_wr_ready_i = 1;
    cyc();

    // R2: fill, refuse extras, drain
    mem_wr_ready_i = 0;
    for (int i = 0; i < N + 2; i++) begin
      if (i == N - 1) chk(full_o == 0, "R2 not full below depth", full_o, 0);
      issue_st(1, 32'h1000 + 32'(i) * 4, 0, 12'h7FF, 1, 32'h11 * 32'(i + 1), 0);
    end
    chk(full_o == 1, "R2 full at depth", full_o, 1);
    mem_wr_ready_i = 1;
    repeat (12) cyc();
    chk(exp_a.size() == 0, "R2 drained", 32'(exp_a.size()), 0);
    chk(full_o == 0 && mem_wr_valid_o == 0, "R8 slots freed", {full_o, mem_wr_valid_o}, 0);

    // R4: base arrives late
    tag_val[3] = 32'h2000;
    issue_st(0, 0, 3, 12'h010, 1, 32'hC0DE, 0);
    for (int i = 0; i < 3; i++) begin
      chk(mem_wr_valid_o == 0, "R4 no address without base", mem_wr_valid_o, 0);
      cyc();
    end
    bcast(3);
    chk(mem_wr_valid_o == 0, "R4 address one edge after base", mem_wr_valid_o, 0);
    cyc();
    chk(mem_wr_valid_o == 1 && mem_wr_addr_o == 32'h2010, "R4 address formed", mem_wr_addr_o, 32'h2010);
    cyc();

    // R5: ready value ignores its tag; other tags ignored
    mem_wr_ready_i = 0;
    tag_val[5] = 32'h99; tag_val[6] = 32'h66; tag_val[7] = 32'h77;
    issue_st(1, 32'h40, 0, 0, 1, 32'h55, 5);
    issue_st(1, 32'h44, 0, 0, 0, 0, 6);
    bcast(5);
    bcast(7);
    chk(mem_wr_valid_o == 1 && mem_wr_data_o == 32'h55, "R5 ready data ignores bus", mem_wr_data_o, 32'h55);
    mem_wr_ready_i = 1;
    cyc();
    cyc();
    chk(mem_wr_valid_o == 0, "R5 unmatched tag ignored", mem_wr_valid_o, 0);
    bcast(6);
    chk(mem_wr_valid_o == 1 && mem_wr_data_o == 32'h66, "R5 data captured", mem_wr_data_o, 32'h66);
    cyc();

    // R6: broadcast in the issue cycle
    mem_wr_ready_i = 0;
    tag_val[9] = 32'h300; tag_val[10] = 32'hA0; tag_val[11] = 32'hB0;
    set_cdb(9);
    issue_st(0, 0, 9, 12'h004, 0, 0, 10);
    set_cdb(11);
    issue_st(1, 32'h500, 0, 0, 0, 0, 11);
    bcast(10);
    chk(mem_wr_valid_o == 1 && mem_wr_addr_o == 32'h304, "R6 base caught at issue", mem_wr_addr_o, 32'h304);
    mem_wr_ready_i = 1;
    cyc();
    chk(mem_wr_valid_o == 1 && mem_wr_data_o == 32'hB0, "R6 data caught at issue", mem_wr_data_o, 32'hB0);
    cyc();

    // R7: younger ready store waits behind older
    tag_val[12] = 32'hE0;
    issue_st(1, 32'h600, 0, 0, 0, 0, 12);
    issue_st(1, 32'h700, 0, 0, 1, 32'hF0, 0);
    for (int i = 0; i < 4; i++) begin
      chk(mem_wr_valid_o == 0, "R7 no overtaking", mem_wr_valid_o, 0);
      cyc();
    end
    bcast(12);
    chk(mem_wr_data_o == 32'hE0, "R7 oldest first", mem_wr_data_o, 32'hE0);
    repeat (3) cyc();
    chk(exp_a.size() == 0, "R7 both written", 32'(exp_a.size()), 0);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      mem_wr_ready_i = ($urandom % 10) < 7;
      if ($urandom % 2) begin
        issue_valid_i    = 1;
        issue_base_rdy_i = ($urandom % 10) < 6;
        issue_base_i     = $urandom;
        issue_base_tag_i = 4'($urandom);
        issue_off_i      = 12'($urandom);
        issue_data_rdy_i = ($urandom % 10) < 6;
        issue_data_i     = $urandom;
        issue_data_tag_i = 4'($urandom);
        if (!issue_base_rdy_i) claim(issue_base_tag_i);
        if (!issue_data_rdy_i) claim(issue_data_tag_i);
      end
      begin
        int r = $urandom % 10;
        int s = $urandom % 16;
        if (r < 4) begin
          for (int k = 0; k < 16; k++) begin
            int t = (s + k) % 16;
            if (pend[t] && !cdb_valid_i) begin
              set_cdb(4'(t));
              pend[t] = 0;
            end
          end
        end else if (r == 4 && !pend[s]) begin
          cdb_valid_i = 1; cdb_tag_i = 4'(s); cdb_value_i = $urandom;
        end
      end
      cyc();
    end

    // drain
    mem_wr_ready_i = 1;
    for (int t = 0; t < 16; t++) begin
      if (pend[t]) begin
        pend[t] = 0;
        bcast(4'(t));
      end
    end
    repeat (40) cyc();
    chk(exp_a.size() == 0, "R8 all stores written", 32'(exp_a.size()), 0);
    chk(full_o == 0 && mem_wr_valid_o == 0, "R1 idle after drain", {full_o, mem_wr_valid_o}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule